// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus transfer at a time for a 16-bit processor core whose address and data share a single set of pins. A request carries a 20-bit address, write data, a direction flag, a memory-or-I/O flag, byte-lane enables and three flags that block bus release. The sequencer steps through an address state, two data states, optional wait states and a closing state. It drives the shared lines, the upper address lines and the bus strobes, then hands back the read data with a done pulse.

A second bus master may claim the bus with a hold request. The sequencer grants it only at points where a grant is allowed. The grant acknowledge and the data-buffer enable change on the falling clock edge, which gives half-cycle timing without a faster clock.

Top module: `busCycleSeq`

## Requirements
- R1: With no request and no hold, ale is 0, rdN, wrN and denN are 1, adOe is 0, done is 0, busOe is 1 and hlda is 0. This is also the state after reset.
- R2: In the address state (the first cycle of a transfer), ale is 1 for exactly that cycle and adOe is 1. adOut carries address bits 15:0. addrHi carries address bits 19:16 for memory and 0 for I/O. bheN is 0 exactly when byte enable bit 1 (upper lane, bits 15:8) is set.
- R3: In a write, adOut carries the write data and adOe is 1 from the second cycle through the closing state. wrN is 0 from the second cycle through the last wait state, and dtR is 1.
- R4: In a read, adOe is 0 after the address state and rdN is 0 from the second cycle through the last wait state. dtR is 0 for the whole transfer. rdData takes adIn at the edge that ends the third cycle or the last wait state. A lane whose enable bit is clear returns zero (bit 0 is bits 7:0, bit 1 is bits 15:8).
- R5: ready is sampled at the end of the third cycle and of each wait state. A 0 adds one wait state. A transfer with n wait states takes 4+n cycles, and done is 1 only in its last cycle.
- R6: denN goes low at the falling edge inside the second cycle. It goes high again at the falling edge inside the closing state.
- R7: mIo is 1 for memory and 0 for I/O, and holds from the address state until the closing state. In a closing state followed at once by a new transfer, mIo already shows the new request's flag.
- R8: A request held valid during the closing state is accepted at its end (reqAccept is 1 in that cycle), and its address state follows with no idle cycle.
- R9: If hold is sampled 1 at the end of the address state or of the second cycle, and none of the lock, split-first or interrupt-ack-first flags is set, the cycle after the closing state releases the bus. busOe and adOe are 0, ale is 0, and hlda rises at that cycle's falling edge.
- R10: If hold is first sampled at the end of the third cycle or later, or the transfer carries a blocking flag, that closing state does not release the bus. A pending request starts instead, and release follows that transfer.
- R11: After hold is sampled 0 at a rising edge while released, hlda falls at the next falling edge and busOe returns to 1.
- R12: When idle, hold takes priority over a pending request. No address state starts and reqAccept stays 0 while hold stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request pending |
| reqAddr | input | 20 | Transfer address |
| reqWData | input | 16 | Write data |
| reqWrite | input | 1 | 1 write, 0 read |
| reqMem | input | 1 | 1 memory, 0 I/O |
| reqByteEn | input | 2 | Byte-lane enables, bit 1 is upper lane |
| reqLock | input | 1 | Transfer is locked, no release |
| reqSplitFirst | input | 1 | Lower half of a split word, no release |
| reqIntaFirst | input | 1 | First interrupt-ack transfer, no release |
| reqAccept | output | 1 | Request taken at this clock edge |
| adIn | input | 16 | Shared lines, inbound value |
| adOut | output | 16 | Shared lines, outbound value |
| adOe | output | 1 | Shared lines output enable |
| addrHi | output | 4 | Upper address lines |
| ale | output | 1 | Address latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| denN | output | 1 | Data buffer enable, active low |
| dtR | output | 1 | Buffer direction, 1 transmit |
| mIo | output | 1 | 1 memory, 0 I/O |
| bheN | output | 1 | Upper-lane enable, active low |
| busOe | output | 1 | Enable for addrHi and all strobes except ale |
| ready | input | 1 | Target ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus released acknowledge |
| done | output | 1 | Transfer finishing this cycle |
| rdData | output | 16 | Captured read data |

## Verification
The bench builds the block with its default widths, 20 address bits and 16 data bits. That gives two byte lanes, so both the upper-lane enable and the masking of a disabled lane appear. It also leaves four upper address lines, where memory and I/O addresses differ. Transfers with zero to two wait states, back-to-back pairs, early and late hold requests, each release-blocking flag and a hold that arrives while idle cover every release path.

// File: rtl/busSeqPkg.sv
`timescale 1ns/1ps
package busSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture a new request
    logic addrPhase;  // address state
    logic dataPhase;  // second cycle through closing state
    logic capture;    // take read data at this edge
    logic inT4;       // closing state
    logic goNext;     // a new transfer starts at this edge
    logic floatBus;   // bus released to another master
  } pathCtl_t;

endpackage

// File: rtl/busSeqCtrl.sv
`timescale 1ns/1ps
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     ready,
  input  logic     hold,
  input  logic     curWrite,
  input  logic     noRelease,
  output pathCtl_t ctl,
  output logic     reqAccept,
  output logic     ale,
  output logic     rdN,
  output logic     wrN,
  output logic     denN,
  output logic     dtR,
  output logic     busOe,
  output logic     hlda,
  output logic     done
);

  busState_e state, nextState;
  logic holdEarly;
  logic releaseNow;
  logic goNext;
  logic strobePhase;
  logic cyclePhase;

  always_comb begin
    releaseNow = hold && holdEarly && !noRelease;
    goNext     = 1'b0;
    nextState  = state;
    unique case (state)
      ST_IDLE: begin
        if (hold) begin
          nextState = ST_HOLD;
        end else if (reqValid) begin
          nextState = ST_T1;
          goNext    = 1'b1;
        end
      end
      ST_T1:        nextState = ST_T2;
      ST_T2:        nextState = ST_T3;
      ST_T3, ST_TW: nextState = ready ? ST_T4 : ST_TW;
      ST_T4: begin
        if (releaseNow) begin
          nextState = ST_HOLD;
        end else if (reqValid) begin
          nextState = ST_T1;
          goNext    = 1'b1;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_HOLD:      if (!hold) nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      holdEarly <= 1'b0;
    end else begin
      state <= nextState;
      if (goNext) begin
        holdEarly <= 1'b0;
      end else if ((state == ST_T1 || state == ST_T2) && hold) begin
        holdEarly <= 1'b1;
      end
    end
  end

  // half-cycle outputs
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      denN <= 1'b1;
      hlda <= 1'b0;
    end else begin
      denN <= !(state inside {ST_T2, ST_T3, ST_TW});
      hlda <= (state == ST_HOLD);
    end
  end

  assign strobePhase = state inside {ST_T2, ST_T3, ST_TW};
  assign cyclePhase  = state inside {ST_T1, ST_T2, ST_T3, ST_TW, ST_T4};

  assign reqAccept = goNext;
  assign ale       = (state == ST_T1);
  assign rdN       = !(strobePhase && !curWrite);
  assign wrN       = !(strobePhase && curWrite);
  assign dtR       = !(cyclePhase && !curWrite);
  assign busOe     = (state != ST_HOLD);
  assign done      = (state == ST_T4);

  always_comb begin
    ctl           = '0;
    ctl.load      = goNext;
    ctl.addrPhase = (state == ST_T1);
    ctl.dataPhase = state inside {ST_T2, ST_T3, ST_TW, ST_T4};
    ctl.capture   = (state == ST_T3 || state == ST_TW) && ready;
    ctl.inT4      = (state == ST_T4);
    ctl.goNext    = goNext;
    ctl.floatBus  = (state == ST_HOLD);
  end

  a_r5_wait_needs_low_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TW) |-> !$past(ready));

  a_r6_den_inside_cycle: assert property (@(posedge clk) disable iff (!rstN)
    !denN |-> (state inside {ST_T2, ST_T3, ST_TW, ST_T4}));

  a_r11_hlda_only_released: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (state == ST_HOLD));

  a_r9_release_needs_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_HOLD) |-> $past(hold));

endmodule

// File: rtl/busSeqPath.sv
`timescale 1ns/1ps
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pathCtl_t                 ctl,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWData,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic [DATA_W/8-1:0]      reqByteEn,
  input  logic                     reqLock,
  input  logic                     reqSplitFirst,
  input  logic                     reqIntaFirst,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     bheN,
  output logic                     mIo,
  output logic [DATA_W-1:0]        rdData,
  output logic                     curWrite,
  output logic                     noRelease
);

  localparam int LANES = DATA_W / 8;
  localparam int HI_W  = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curData;
  logic              curMem;
  logic [LANES-1:0]  curBe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      curData   <= '0;
      curWrite  <= 1'b0;
      curMem    <= 1'b0;
      curBe     <= '0;
      noRelease <= 1'b0;
    end else if (ctl.load) begin
      curAddr   <= reqAddr;
      curData   <= reqWData;
      curWrite  <= reqWrite;
      curMem    <= reqMem;
      curBe     <= reqByteEn;
      noRelease <= reqLock || reqSplitFirst || reqIntaFirst;
    end
  end

  assign adOut  = ctl.addrPhase ? curAddr[DATA_W-1:0] : curData;
  assign adOe   = !ctl.floatBus && (ctl.addrPhase || (ctl.dataPhase && curWrite));
  assign addrHi = (ctl.addrPhase && curMem) ? curAddr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  assign bheN   = !(ctl.addrPhase && curBe[LANES-1]);
  assign mIo    = ctl.goNext ? reqMem : curMem;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= 8'h00;
      end else if (ctl.capture && !curWrite) begin
        laneQ <= curBe[g] ? adIn[g*8 +: 8] : 8'h00;
      end
    end
    assign rdData[g*8 +: 8] = laneQ;
  end

  a_r7_mio_steady: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dataPhase && !ctl.inT4) |-> $stable(mIo));

endmodule

// File: rtl/busCycleSeq.sv
`timescale 1ns/1ps
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWData,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic [DATA_W/8-1:0]      reqByteEn,
  input  logic                     reqLock,
  input  logic                     reqSplitFirst,
  input  logic                     reqIntaFirst,
  output logic                     reqAccept,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     denN,
  output logic                     dtR,
  output logic                     mIo,
  output logic                     bheN,
  output logic                     busOe,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData
);

  pathCtl_t ctl;
  logic     curWrite;
  logic     noRelease;

  busSeqCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .ready     (ready),
    .hold      (hold),
    .curWrite  (curWrite),
    .noRelease (noRelease),
    .ctl       (ctl),
    .reqAccept (reqAccept),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN),
    .denN      (denN),
    .dtR       (dtR),
    .busOe     (busOe),
    .hlda      (hlda),
    .done      (done)
  );

  busSeqPath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .reqAddr       (reqAddr),
    .reqWData      (reqWData),
    .reqWrite      (reqWrite),
    .reqMem        (reqMem),
    .reqByteEn     (reqByteEn),
    .reqLock       (reqLock),
    .reqSplitFirst (reqSplitFirst),
    .reqIntaFirst  (reqIntaFirst),
    .adIn          (adIn),
    .adOut         (adOut),
    .adOe          (adOe),
    .addrHi        (addrHi),
    .bheN          (bheN),
    .mIo           (mIo),
    .rdData        (rdData),
    .curWrite      (curWrite),
    .noRelease     (noRelease)
  );

  a_r2_ale_with_address: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> adOe);

  a_r4_read_lines_released: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  a_r3_write_lines_driven: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe);

  a_r9_float_when_granted: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (!adOe && !busOe && !ale));

endmodule

// File: tb/tb_busCycleSeq.sv
`timescale 1ns/1ps
module tb_busCycleSeq;

  typedef struct {
    logic [19:0] addr;
    logic [15:0] wdata;
    logic        wr;
    logic        mem;
    logic [1:0]  be;
    int          waits;
    logic [15:0] src;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic        reqWrite = 1'b0;
  logic        reqMem = 1'b0;
  logic [1:0]  reqByteEn = '0;
  logic        reqLock = 1'b0;
  logic        reqSplitFirst = 1'b0;
  logic        reqIntaFirst = 1'b0;
  logic        reqAccept;
  logic [15:0] adIn = '0;
  logic [15:0] adOut;
  logic        adOe;
  logic [3:0]  addrHi;
  logic        ale, rdN, wrN, denN, dtR, mIo, bheN, busOe;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic        hlda, done;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int doneCyc = 0;
  int aleGap = 0;
  int k = 0;
  bit inCyc = 0;
  item_t expQ[$];
  item_t cur;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  busCycleSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWData(reqWData), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqByteEn(reqByteEn), .reqLock(reqLock), .reqSplitFirst(reqSplitFirst),
    .reqIntaFirst(reqIntaFirst), .reqAccept(reqAccept), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .addrHi(addrHi), .ale(ale), .rdN(rdN),
    .wrN(wrN), .denN(denN), .dtR(dtR), .mIo(mIo), .bheN(bheN),
    .busOe(busOe), .ready(ready), .hold(hold), .hlda(hlda), .done(done),
    .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic sendReq(input logic [19:0] a, input logic [15:0] wd, input logic wr,
                         input logic mem, input logic [1:0] be, input int waits,
                         input logic [15:0] src, input logic lk, input logic sp,
                         input logic ia);
    item_t it;
    it.addr = a; it.wdata = wd; it.wr = wr; it.mem = mem;
    it.be = be; it.waits = waits; it.src = src;
    expQ.push_back(it);
    reqAddr = a; reqWData = wd; reqWrite = wr; reqMem = mem; reqByteEn = be;
    reqLock = lk; reqSplitFirst = sp; reqIntaFirst = ia;
    reqValid = 1'b1;
    forever begin
      @(negedge clk);
      if (reqAccept) break;
    end
    @(posedge clk); #1.5;
    reqValid = 1'b0; reqLock = 1'b0; reqSplitFirst = 1'b0; reqIntaFirst = 1'b0;
  endtask

  task automatic waitIdle();
    do begin
      @(posedge clk); #1.5;
    end while (inCyc || expQ.size() > 0);
    @(posedge clk); #1.5;
  endtask

  task automatic waitDone();
    do begin
      @(posedge clk); #1.5;
    end while (!done);
  endtask

  // monitor / scoreboard
  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (rstN) begin
        if (!inCyc) begin
          if (ale) begin
            if (expQ.size() == 0) begin
              chk("R2 address state without request", 1, 0);
            end else begin
              cur = expQ.pop_front();
              inCyc = 1; k = 1;
              aleGap = cyc - doneCyc;
              chk("R2 adOut address", adOut, cur.addr[15:0]);
              chk("R2 adOe", adOe, 1);
              chk("R2 addrHi", addrHi, cur.mem ? cur.addr[19:16] : 4'h0);
              chk("R2 bheN", bheN, !cur.be[1]);
              chk("R7 mIo", mIo, cur.mem);
              chk("R4 R3 dtR", dtR, cur.wr);
              adIn = cur.src;
              ready = (k >= 3 + cur.waits);
            end
          end
        end else begin
          k++;
          if (k <= 3 + cur.waits) begin
            chk("R2 ale single cycle", ale, 0);
            chk("R4 rdN", rdN, cur.wr);
            chk("R3 wrN", wrN, !cur.wr);
            chk("R3 R4 adOe", adOe, cur.wr);
            if (cur.wr) chk("R3 write data", adOut, cur.wdata);
            chk("R4 R3 dtR", dtR, cur.wr);
            chk("R7 mIo", mIo, cur.mem);
            chk("R5 done early", done, 0);
            chk("R6 denN", denN, (k == 2) ? 1 : 0);
            ready = (k >= 3 + cur.waits);
          end else begin
            chk("R5 done in closing state", done, 1);
            chk("R6 denN still low", denN, 0);
            chk("R4 rdN off", rdN, 1);
            chk("R3 wrN off", wrN, 1);
            chk("R3 R4 adOe closing", adOe, cur.wr);
            if (cur.wr) chk("R3 write data closing", adOut, cur.wdata);
            else chk("R4 rdData", rdData,
                     {cur.be[1] ? cur.src[15:8] : 8'h00, cur.be[0] ? cur.src[7:0] : 8'h00});
            adIn = ~cur.src;
            ready = 1'b1;
            inCyc = 0;
            doneCyc = cyc;
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset / idle state
    @(posedge clk); #1.5;
    chk("R1 ale", ale, 0); chk("R1 rdN", rdN, 1); chk("R1 wrN", wrN, 1);
    chk("R1 denN", denN, 1); chk("R1 adOe", adOe, 0); chk("R1 done", done, 0);
    chk("R1 busOe", busOe, 1); chk("R1 hlda", hlda, 0);

    // R2 R4 R5 R6 memory read, no wait
    sendReq(20'hA1234, 16'h0, 0, 1, 2'b11, 0, 16'hBEEF, 0, 0, 0);
    waitIdle();
    // R3 R5 memory write, two waits, upper lane only
    sendReq(20'h5_6789, 16'hC0DE, 1, 1, 2'b10, 2, 16'h0, 0, 0, 0);
    waitIdle();
    // R2 R4 R7 I/O read, one wait, lower lane only
    sendReq(20'hF_0042, 16'h0, 0, 0, 2'b01, 1, 16'h7E81, 0, 0, 0);
    waitIdle();

    // R7 R8 back-to-back: memory read then I/O write
    sendReq(20'h1_0010, 16'h0, 0, 1, 2'b11, 0, 16'h3344, 0, 0, 0);
    fork
      sendReq(20'h0_0300, 16'h9911, 1, 0, 2'b11, 1, 16'h0, 0, 0, 0);
      begin
        waitDone();
        chk("R7 mIo shows next request in closing state", mIo, 0);
      end
    join
    waitDone();
    chk("R8 no idle cycle between transfers", aleGap, 1);
    waitIdle();

    // R9 R11 early hold releases after the closing state
    sendReq(20'h2_2222, 16'h0, 0, 1, 2'b11, 1, 16'h1357, 0, 0, 0);
    hold = 1'b1;
    waitDone();
    @(posedge clk); #1.5;
    chk("R9 busOe floats", busOe, 0);
    chk("R9 adOe floats", adOe, 0);
    chk("R9 ale low", ale, 0);
    chk("R9 hlda not before falling edge", hlda, 0);
    #2;
    chk("R9 hlda at falling edge", hlda, 1);
    hold = 1'b0;
    @(posedge clk); #1.5;
    chk("R11 hlda held until falling edge", hlda, 1);
    chk("R11 busOe back", busOe, 1);
    #2;
    chk("R11 hlda drops", hlda, 0);
    waitIdle();

    // R10 late hold: next request runs, release after it
    sendReq(20'h3_0400, 16'h0, 0, 1, 2'b11, 2, 16'h2468, 0, 0, 0);
    do begin @(posedge clk); #1.5; end while (!(inCyc && k == 3));
    hold = 1'b1;
    sendReq(20'h3_0402, 16'hAAAA, 1, 1, 2'b11, 0, 16'h0, 0, 0, 0);
    chk("R10 late hold lets next transfer start", ale, 1);
    waitDone();
    @(posedge clk); #1.5;
    chk("R10 release after following transfer", busOe, 0);
    hold = 1'b0;
    repeat (2) @(posedge clk); #1.5;
    chk("R11 bus regained", busOe, 1);
    waitIdle();

    // R10 each blocking flag prevents release at its closing state
    for (int f = 0; f < 3; f++) begin
      sendReq(20'h4_0000 + 20'(f * 4), 16'h0, 0, 1, 2'b11, 0, 16'h5A5A,
              f == 0, f == 1, f == 2);
      hold = 1'b1;
      sendReq(20'h4_0100, 16'h0F0F, 1, 1, 2'b11, 0, 16'h0, 0, 0, 0);
      chk("R10 blocked transfer keeps bus", ale, 1);
      waitDone();
      @(posedge clk); #1.5;
      chk("R10 release after unblocked transfer", busOe, 0);
      hold = 1'b0;
      repeat (2) @(posedge clk); #1.5;
      waitIdle();
    end

    // R12 hold while idle beats a pending request
    hold = 1'b1;
    @(posedge clk); #1.5;
    chk("R12 idle hold releases", busOe, 0);
    fork
      sendReq(20'h6_0006, 16'h0, 0, 1, 2'b11, 0, 16'h0110, 0, 0, 0);
      begin
        for (int i = 0; i < 3; i++) begin
          @(posedge clk); #1.5;
          chk("R12 no address state during hold", ale, 0);
          chk("R12 no accept during hold", reqAccept, 0);
        end
        hold = 1'b0;
      end
    join
    waitIdle();

    // R1 idle again
    chk("R1 idle ale", ale, 0); chk("R1 idle denN", denN, 1);
    chk("R1 idle hlda", hlda, 0); chk("R1 idle busOe", busOe, 1);

    summary();
    $finish;
  end

endmodule